// File: doc/BRIEF.md
# Power-up Reset Sequencer

This block merges every reset cause of a chip into one internal reset, `chip_rst_n`, and releases it only after a fixed chain of waiting stages. The inputs are a power-on reset line, a digitised supply-low flag from a comparator, a wake request, an external or watchdog reset request, and three static configuration settings. The configuration chooses whether the power-up delay is used, whether brown-out reset is on, and which oscillator mode is in use. The stages are a brown-out glitch filter, a power-up delay counted on a free-running RC clock, and an oscillator settling count measured on the main oscillator clock.

After any reset, the sequencer waits for the supply to recover. It then counts the power-up delay. If a crystal mode is in use and the reset came from power-on, it then counts oscillator cycles before it lets the chip run. A supply dip during the power-up delay sends the sequencer back to its hold state, and the delay then starts again from zero. Two sticky flags record whether a power-on or a brown-out event has occurred, and an explicit clear strobe resets both.

The sequencer logic runs on the RC clock. The other asynchronous inputs reach it through synchronisers. The oscillator-side counter reports back through a four-phase request/acknowledge handshake.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While `pwr_on_n` is low, and just after it rises, `chip_rst_n` is 0 and `seq_state` is 0. After a power-on event, `cause_por` reads 1 and `cause_bod` reads 0. The `seq_state` codes are 0 hold, 1 power-up delay, 2 oscillator settling and 3 run.
- R2: The sequencer stays in hold (code 0) while the synchronised `vdd_low` or `sys_rst_req` is high.
- R3: When `cfg_pwrt_off` is 0, the power-up delay state (code 1) lasts exactly `PWRT_CYC` RC cycles. When `cfg_pwrt_off` is 1, hold moves on without visiting code 1.
- R4: If `vdd_low` rises during the power-up delay, the sequencer returns to hold. The next power-up delay then lasts the full `PWRT_CYC` cycles.
- R5: The oscillator settling state (code 2) is entered only when `cfg_osc_mode` is not 3. The mode codes are 0 LP, 1 XT, 2 HS and 3 no crystal. A further condition applies: either the reset came from power-on with no brown-out or external reset since, or a rising `wake_req` arrived in run. The state holds reset until `OST_CYC` cycles of `osc_clk` have been counted.
- R6: A rising `wake_req` in run has no effect when `cfg_osc_mode` is 3.
- R7: In run with `cfg_bod_en` at 1, `vdd_low` high for `TBOD_CYC`+1 consecutive RC cycles causes a reset. A dip of `TBOD_CYC` cycles or fewer does not.
- R8: In run with `cfg_bod_en` at 0, `vdd_low` has no effect.
- R9: A high `sys_rst_req` in run returns the sequencer to hold. The restart then skips oscillator settling.
- R10: `cause_bod` is set by every brown-out return to hold, which covers a filter trip in run and a supply dip during a delay stage. Both cause flags stay set until a `clr_cause` cycle clears them.
- R11: `chip_rst_n` is high exactly when `seq_state` is 3. It is therefore released in the RC cycle after the last enabled stage finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Free-running internal RC clock; drives the sequencer |
| osc_clk | input | 1 | Main oscillator clock; drives the settling counter |
| pwr_on_n | input | 1 | Active-low power-on reset, asynchronous assert |
| vdd_low | input | 1 | Supply below brown-out threshold, asynchronous |
| wake_req | input | 1 | Wake-from-sleep request, rising edge used |
| sys_rst_req | input | 1 | External or watchdog reset request, level |
| cfg_pwrt_off | input | 1 | 1 skips the power-up delay |
| cfg_bod_en | input | 1 | 1 enables brown-out reset |
| cfg_osc_mode | input | 2 | 0 LP, 1 XT, 2 HS, 3 no crystal |
| clr_cause | input | 1 | RC-synchronous strobe clearing both cause flags |
| chip_rst_n | output | 1 | Internal chip reset, active low |
| seq_state | output | 2 | Current sequencer state code |
| cause_por | output | 1 | Sticky power-on cause flag |
| cause_bod | output | 1 | Sticky brown-out cause flag |

## Verification
The assertions make two assumptions about the inputs. The configuration inputs must stay static while the sequencer is out of hold. `clr_cause` must be synchronous to `rc_clk`. The handshake checks also assume that `osc_clk` runs while a settling count is requested. The bench holds every configuration change to moments when the sequencer is settled in run or held in power-on reset. It drives `clr_cause` for one RC cycle at a falling edge, and it keeps `osc_clk` running throughout. Supply dips are driven with whole RC-cycle lengths, so the filter boundary at `TBOD_CYC` is hit exactly.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_PWRT = 2'd1,
    ST_OST  = 2'd2,
    ST_RUN  = 2'd3
  } rsq_state_e;

  localparam logic [1:0] OSC_NOXTAL = 2'd3;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int unsigned       WIDTH   = 1,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rsq_bod_filt.sv
module rsq_bod_filt #(
  parameter int unsigned TBOD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic below,
  output logic trip
);
  localparam int unsigned CW = $clog2(TBOD_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(TBOD_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en || !below) cnt_d = '0;
    else if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // trip when the flag is high now and was high on the TBOD_CYC cycles before
  assign trip = en & below & (cnt_q == CNT_TOP);

  AST_TRIP_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> $past(below) && $past(en)); // R7
endmodule

// File: rtl/rsq_ost.sv
module rsq_ost #(
  parameter int unsigned OST_CYC     = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic osc_rst_n,
  input  logic req,
  output logic ack
);
  localparam int unsigned CW = $clog2(OST_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OST_CYC - 1);

  logic          req_s;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_q, ack_d;

  rsq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk   (osc_clk),
    .rst_n (osc_rst_n),
    .d     (req),
    .q     (req_s)
  );

  always_comb begin
    cnt_d = cnt_q;
    ack_d = ack_q;
    if (!req_s) begin
      cnt_d = '0;
      ack_d = 1'b0;
    end else if (!ack_q) begin
      if (cnt_q == CNT_LAST) ack_d = 1'b1;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ack_q <= ack_d;
    end
  end

  assign ack = ack_q;

  AST_ACK_AFTER_FULL_COUNT: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    $rose(ack_q) |-> $past(req_s) && ($past(cnt_q) == CNT_LAST)); // R5
  AST_ACK_DROPS_WITH_REQ: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    !req_s |=> !ack_q); // R5
endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
  import rsq_pkg::*;
#(
  parameter int unsigned PWRT_CYC    = 2048,
  parameter int unsigned TBOD_CYC    = 16,
  parameter int unsigned OST_CYC     = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       rc_clk,
  input  logic       osc_clk,
  input  logic       pwr_on_n,
  input  logic       vdd_low,
  input  logic       wake_req,
  input  logic       sys_rst_req,
  input  logic       cfg_pwrt_off,
  input  logic       cfg_bod_en,
  input  logic [1:0] cfg_osc_mode,
  input  logic       clr_cause,
  output logic       chip_rst_n,
  output logic [1:0] seq_state,
  output logic       cause_por,
  output logic       cause_bod
);
  localparam int unsigned PW = (PWRT_CYC > 1) ? $clog2(PWRT_CYC) : 1;
  localparam logic [PW-1:0] PWRT_LAST = PW'(PWRT_CYC - 1);

  // ---------------- reset and input synchronisers ----------------
  logic       rc_rst_n;
  logic       osc_rst_n;
  logic [2:0] raw_in;
  logic [2:0] sync_in;
  logic       below_s, wake_s, ext_s;

  rsq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rc_rst (
    .clk (rc_clk), .rst_n (pwr_on_n), .d (1'b1), .q (rc_rst_n)
  );

  rsq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_osc_rst (
    .clk (osc_clk), .rst_n (pwr_on_n), .d (1'b1), .q (osc_rst_n)
  );

  assign raw_in = {vdd_low, wake_req, sys_rst_req};

  // supply-low resets to 1 so hold cannot be left before the flag is sampled
  rsq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_in_sync (
    .clk (rc_clk), .rst_n (rc_rst_n), .d (raw_in), .q (sync_in)
  );

  assign below_s = sync_in[2];
  assign wake_s  = sync_in[1];
  assign ext_s   = sync_in[0];

  // ---------------- brown-out filter ----------------
  logic bod_trip;

  rsq_bod_filt #(.TBOD_CYC(TBOD_CYC)) u_bod (
    .clk (rc_clk), .rst_n (rc_rst_n), .en (cfg_bod_en), .below (below_s), .trip (bod_trip)
  );

  // ---------------- oscillator settling counter ----------------
  logic ost_req_q, ost_req_d;
  logic ost_ack, ack_s;

  rsq_ost #(.OST_CYC(OST_CYC), .SYNC_STAGES(SYNC_STAGES)) u_ost (
    .osc_clk (osc_clk), .osc_rst_n (osc_rst_n), .req (ost_req_q), .ack (ost_ack)
  );

  rsq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
    .clk (rc_clk), .rst_n (rc_rst_n), .d (ost_ack), .q (ack_s)
  );

  // ---------------- sequencer ----------------
  rsq_state_e    state_q, state_d;
  logic [PW-1:0] pwrt_q, pwrt_d;
  logic          arm_q, arm_d;       // settling count owed by a power-on
  logic          idle_q, idle_d;     // acknowledge seen low in this settling pass
  logic          wake_q;
  logic          por_q, por_d;
  logic          bod_q, bod_d;
  logic          xtal;
  logic          wake_edge;

  assign xtal      = (cfg_osc_mode != OSC_NOXTAL);
  assign wake_edge = wake_s & ~wake_q;

  always_comb begin
    state_d = state_q;
    pwrt_d  = pwrt_q;
    arm_d   = arm_q;
    idle_d  = idle_q;
    por_d   = por_q;
    bod_d   = bod_q;
    if (clr_cause) begin
      por_d = 1'b0;
      bod_d = 1'b0;
    end
    unique case (state_q)
      ST_HOLD: begin
        pwrt_d = '0;
        idle_d = 1'b0;
        if (!below_s && !ext_s) begin
          if (!cfg_pwrt_off)      state_d = ST_PWRT;
          else if (arm_q && xtal) state_d = ST_OST;
          else                    state_d = ST_RUN;
        end
      end
      ST_PWRT: begin
        if (ext_s) begin
          state_d = ST_HOLD;
          arm_d   = 1'b0;
        end else if (below_s) begin
          state_d = ST_HOLD;
          arm_d   = 1'b0;
          bod_d   = 1'b1;
        end else if (pwrt_q == PWRT_LAST) begin
          state_d = (arm_q && xtal) ? ST_OST : ST_RUN;
        end else begin
          pwrt_d = pwrt_q + 1'b1;
        end
      end
      ST_OST: begin
        if (ext_s) begin
          state_d = ST_HOLD;
          arm_d   = 1'b0;
        end else if (below_s) begin
          state_d = ST_HOLD;
          arm_d   = 1'b0;
          bod_d   = 1'b1;
        end else begin
          if (!ack_s) idle_d = 1'b1;
          if (ack_s && idle_q) state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        arm_d = 1'b0;
        if (ext_s) begin
          state_d = ST_HOLD;
        end else if (bod_trip) begin
          state_d = ST_HOLD;
          bod_d   = 1'b1;
        end else if (wake_edge && xtal) begin
          state_d = ST_OST;
          idle_d  = 1'b0;
        end
      end
      default: state_d = ST_HOLD;
    endcase
    ost_req_d = (state_d == ST_OST) && idle_d;
  end

  always_ff @(posedge rc_clk or negedge rc_rst_n) begin
    if (!rc_rst_n) begin
      state_q   <= ST_HOLD;
      pwrt_q    <= '0;
      arm_q     <= 1'b1;
      idle_q    <= 1'b0;
      wake_q    <= 1'b0;
      por_q     <= 1'b1;
      bod_q     <= 1'b0;
      ost_req_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      pwrt_q    <= pwrt_d;
      arm_q     <= arm_d;
      idle_q    <= idle_d;
      wake_q    <= wake_s;
      por_q     <= por_d;
      bod_q     <= bod_d;
      ost_req_q <= ost_req_d;
    end
  end

  assign chip_rst_n = (state_q == ST_RUN);
  assign seq_state  = state_q;
  assign cause_por  = por_q;
  assign cause_bod  = bod_q;

  // ---------------- assertions ----------------
  AST_HOLD_WHILE_LOW: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
    (state_q == ST_HOLD) && (below_s || ext_s) |=> (state_q == ST_HOLD)); // R2
  AST_PWRT_FULL_LENGTH: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
    $fell(state_q == ST_PWRT) && (state_q != ST_HOLD) |-> ($past(pwrt_q) == PWRT_LAST)); // R3
  AST_PWRT_RESTART: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
    (state_q == ST_PWRT) && below_s |=> (state_q == ST_HOLD)); // R4
  AST_OST_ONLY_XTAL: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
    $rose(state_q == ST_OST) |-> $past(xtal)); // R5
  AST_RUN_AFTER_STAGE: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
    $rose(state_q == ST_RUN) |-> ($past(state_q) == ST_PWRT) || ($past(state_q) == ST_OST)
                                 || $past(cfg_pwrt_off)); // R11
  AST_BOD_STICKY: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
    bod_q && !clr_cause |=> bod_q); // R10
  AST_POR_STICKY: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
    por_q && !clr_cause |=> por_q); // R10
endmodule

// File: tb/pwrup_rst_seq_bench.sv
module pwrup_rst_seq_bench;
  localparam int P    = 40;
  localparam int TB   = 6;
  localparam int OSTC = 64;
  localparam int OLO  = 33;
  localparam int OHI  = 48;
  localparam int ANY  = 1000000;

  logic       rc_clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       pwr_on_n, vdd_low, wake_req, sys_rst_req;
  logic       cfg_pwrt_off, cfg_bod_en, clr_cause;
  logic [1:0] cfg_osc_mode;
  logic       chip_rst_n, cause_por, cause_bod;
  logic [1:0] seq_state;

  always #10 rc_clk = ~rc_clk;   // 50 MHz
  always #5  osc_clk = ~osc_clk;

  pwrup_rst_seq #(.PWRT_CYC(P), .TBOD_CYC(TB), .OST_CYC(OSTC)) u_pwrup_rst_seq (
    .rc_clk, .osc_clk, .pwr_on_n, .vdd_low, .wake_req, .sys_rst_req,
    .cfg_pwrt_off, .cfg_bod_en, .cfg_osc_mode, .clr_cause,
    .chip_rst_n, .seq_state, .cause_por, .cause_bod
  );

  typedef struct {
    logic [1:0] st;
    int         lo;
    int         hi;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, expv);
    end
  endtask

  task automatic expect_st(input logic [1:0] st, input int lo, input int hi, input string tag);
    exp_t it;
    it.st = st; it.lo = lo; it.hi = hi; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge rc_clk);
    repeat (4) @(negedge rc_clk);
  endtask

  // monitor: pops one expected item per observed state change
  logic [1:0] prev_st;
  int         run_len;
  always @(negedge rc_clk) begin
    if (!mon_on) begin
      prev_st = seq_state;
      run_len = 1;
    end else if (seq_state !== prev_st) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected state change", int'(seq_state), int'(prev_st));
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        chk(seq_state === it.st, it.tag, "next state", int'(seq_state), int'(it.st));
        chk(run_len >= it.lo && run_len <= it.hi, it.tag, "cycles in previous state", run_len, it.lo);
      end
      chk(chip_rst_n === (seq_state == 2'd3), "R11", "reset vs run", int'(chip_rst_n), int'(seq_state == 2'd3));
      prev_st = seq_state;
      run_len = 1;
    end else begin
      run_len++;
    end
  end

  task automatic wait_state(input logic [1:0] st);
    while (seq_state !== st) @(negedge rc_clk);
  endtask

  task automatic power_on();
    @(negedge rc_clk);
    #2 pwr_on_n = 1'b0;
    repeat (3) @(negedge rc_clk);
    #2 pwr_on_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge rc_clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog all-requirements act=timeout exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    pwr_on_n = 1'b1; vdd_low = 1'b1; wake_req = 1'b0; sys_rst_req = 1'b0;
    cfg_pwrt_off = 1'b0; cfg_bod_en = 1'b1; cfg_osc_mode = 2'd1; clr_cause = 1'b0;
    #5 pwr_on_n = 1'b0;
    repeat (3) @(negedge rc_clk);
    // R1: reset state
    chk(chip_rst_n === 1'b0, "R1", "chip_rst_n in power-on", int'(chip_rst_n), 0);
    chk(seq_state === 2'd0, "R1", "state in power-on", int'(seq_state), 0);
    chk(cause_por === 1'b1, "R1", "cause_por", int'(cause_por), 1);
    chk(cause_bod === 1'b0, "R1", "cause_bod", int'(cause_bod), 0);

    // power-up with crystal XT: delay then settling
    expect_st(2'd1, 0, ANY, "R2");
    expect_st(2'd2, P, P, "R3");
    expect_st(2'd3, OLO, OHI, "R5");
    mon_on = 1'b1;
    @(negedge rc_clk);
    pwr_on_n = 1'b1;
    repeat (12) @(negedge rc_clk);
    chk(seq_state === 2'd0, "R2", "hold while supply low", int'(seq_state), 0);
    vdd_low = 1'b0;
    drain();
    chk(chip_rst_n === 1'b1, "R11", "released after settling", int'(chip_rst_n), 1);

    // R7: dip of exactly TBOD cycles is filtered
    vdd_low = 1'b1;
    repeat (TB) @(negedge rc_clk);
    vdd_low = 1'b0;
    repeat (10) @(negedge rc_clk);
    chk(seq_state === 2'd3, "R7", "short dip ignored", int'(seq_state), 3);

    // R7/R10: dip longer than TBOD resets, no settling afterwards
    expect_st(2'd0, 0, ANY, "R7");
    expect_st(2'd1, 0, ANY, "R7");
    expect_st(2'd3, P, P, "R5");
    vdd_low = 1'b1;
    repeat (TB + 4) @(negedge rc_clk);
    vdd_low = 1'b0;
    drain();
    chk(cause_bod === 1'b1, "R10", "cause_bod after brown-out", int'(cause_bod), 1);
    chk(cause_por === 1'b1, "R10", "cause_por still set", int'(cause_por), 1);

    // R10: clear strobe
    clr_cause = 1'b1;
    @(negedge rc_clk);
    clr_cause = 1'b0;
    repeat (2) @(negedge rc_clk);
    chk(cause_bod === 1'b0, "R10", "cause_bod cleared", int'(cause_bod), 0);
    chk(cause_por === 1'b0, "R10", "cause_por cleared", int'(cause_por), 0);

    // R9 + R4: external reset, then a dip in the middle of the delay
    expect_st(2'd0, 0, ANY, "R9");
    expect_st(2'd1, 0, ANY, "R9");
    expect_st(2'd0, 0, ANY, "R4");
    expect_st(2'd1, 0, ANY, "R4");
    expect_st(2'd3, P, P, "R4");
    sys_rst_req = 1'b1;
    repeat (4) @(negedge rc_clk);
    sys_rst_req = 1'b0;
    wait_state(2'd1);
    repeat (10) @(negedge rc_clk);
    vdd_low = 1'b1;
    repeat (3) @(negedge rc_clk);
    vdd_low = 1'b0;
    drain();
    chk(cause_bod === 1'b1, "R10", "cause_bod after dip in delay", int'(cause_bod), 1);

    // R8: brown-out disabled
    cfg_bod_en = 1'b0;
    vdd_low = 1'b1;
    repeat (20) @(negedge rc_clk);
    vdd_low = 1'b0;
    repeat (6) @(negedge rc_clk);
    chk(seq_state === 2'd3, "R8", "dip ignored with brown-out off", int'(seq_state), 3);
    cfg_bod_en = 1'b1;

    // R6: wake without crystal
    cfg_osc_mode = 2'd3;
    wake_req = 1'b1;
    repeat (3) @(negedge rc_clk);
    wake_req = 1'b0;
    repeat (10) @(negedge rc_clk);
    chk(seq_state === 2'd3, "R6", "wake ignored in mode 3", int'(seq_state), 3);

    // R5: wake with LP crystal runs settling only
    cfg_osc_mode = 2'd0;
    expect_st(2'd2, 0, ANY, "R5");
    expect_st(2'd3, OLO, OHI, "R5");
    wake_req = 1'b1;
    repeat (3) @(negedge rc_clk);
    wake_req = 1'b0;
    drain();

    // R3: delay disabled, external reset, HS
    cfg_pwrt_off = 1'b1;
    cfg_osc_mode = 2'd2;
    expect_st(2'd0, 0, ANY, "R3");
    expect_st(2'd3, 0, ANY, "R3");
    sys_rst_req = 1'b1;
    repeat (4) @(negedge rc_clk);
    sys_rst_req = 1'b0;
    drain();

    // R5 + R1: power-on with delay disabled and XT: settling directly
    cfg_osc_mode = 2'd1;
    expect_st(2'd0, 0, ANY, "R1");
    expect_st(2'd2, 0, ANY, "R5");
    expect_st(2'd3, OLO, OHI, "R5");
    power_on();
    drain();
    chk(cause_por === 1'b1, "R1", "cause_por after power-on", int'(cause_por), 1);
    chk(cause_bod === 1'b0, "R1", "cause_bod after power-on", int'(cause_bod), 0);

    // R5: power-on without crystal skips settling
    cfg_pwrt_off = 1'b0;
    cfg_osc_mode = 2'd3;
    expect_st(2'd0, 0, ANY, "R1");
    expect_st(2'd1, 0, ANY, "R3");
    expect_st(2'd3, P, P, "R5");
    power_on();
    drain();
    chk(chip_rst_n === 1'b1, "R11", "final release", int'(chip_rst_n), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule